// File: doc/BRIEF.md
# Two-Lane Result Bus Arbiter

This block picks which finished functional units may broadcast their results on a result bus with two lanes. Seven units feed it: multiply, memory, ALU, integer divide, FP divide, FP multiply and FP add. Each unit offers a reorder-buffer tag, a destination register, result data and an exception flag. In every cycle the arbiter puts the requester with the highest fixed priority on lane 0 and the next one on lane 1. Logic further down the bus uses the lanes to wake waiting operands and to mark reorder-buffer entries complete.

A unit that offers a result but is not granted loses nothing. Its result moves into a single-entry holding slot for that unit, and the unit sees `fu_ready` low until the slot wins the bus. A held result keeps the priority of its unit. It is offered in place of any newer output from that unit. A flush empties every slot and keeps both lanes quiet in that cycle.

Each holding slot is a two-state machine. In state SLOT_EMPTY, an offered result that is not granted moves the slot to SLOT_HELD; an offered result that is granted, or no offer, leaves the slot in SLOT_EMPTY. In state SLOT_HELD, a grant with no new offer moves the slot back to SLOT_EMPTY. A grant together with a new offer reloads the slot and keeps it in SLOT_HELD. With no grant the slot stays in SLOT_HELD. From either state, a flush moves the slot to SLOT_EMPTY. The lane choice itself is combinational, so a fresh result that wins goes out in the cycle it is offered.

Top module: `cdb_two_lane_arb`

## Requirements
- R1: In every cycle without a flush, the arbiter grants the two highest-priority requesters, at most two. A unit requests when its slot holds a result or when it asserts `fu_done`. Lane 0 carries the higher-priority requester and lane 1 the next one.
- R2: Unit index sets the priority, and index 0 is highest. The order is 0 multiply, 1 memory, 2 ALU, 3 integer divide, 4 FP divide, 5 FP multiply, 6 FP add.
- R3: With exactly one requester, lane 0 is valid and lane 1 is invalid. With no requester, both lanes are invalid.
- R4: Lane 1 is never valid while lane 0 is invalid.
- R5: A completion that is offered while the unit is ready, and is not granted, is kept in that unit's slot. In later cycles it is offered with unchanged fields, and it is granted exactly once. While it waits ungranted, `fu_ready` of that unit is low.
- R6: While a unit's slot is full, the slot's result is the one the unit offers to the arbiter. If `fu_ready` is low, a new `fu_done` from that unit is ignored and does not replace the held result.
- R7: `fu_ready` is high when the unit's slot is empty or when the slot is granted in that cycle. A completion accepted in the same cycle that the held result is granted is offered in the next cycle.
- R8: While `flush` is high, both lanes are invalid and `fu_ready` is high for every unit. After that clock edge every slot is empty, and results that were held or offered during the flush are never broadcast.
- R9: A valid lane carries the tag, destination register, data and exception flag of the granted result without change. In the packed payload the tag is the top field, followed by the destination register, the data, and the exception flag in bit 0.
- R10: After reset, every slot is empty, both lanes are invalid, and every `fu_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| flush | input | 1 | Discards held and offered results, silences the lanes |
| fu_done | input | NUM_UNITS | Per unit: a completed result is offered |
| fu_tag | input | NUM_UNITS x TAG_W | Per unit: reorder-buffer tag of the offered result |
| fu_rd | input | NUM_UNITS x RD_W | Per unit: destination register |
| fu_data | input | NUM_UNITS x DATA_W | Per unit: result value |
| fu_exc | input | NUM_UNITS | Per unit: exception flag |
| fu_ready | output | NUM_UNITS | Per unit: an offer in this cycle is accepted |
| lane0_vld | output | 1 | Lane 0 carries a result |
| lane0_tag | output | TAG_W | Lane 0 tag |
| lane0_rd | output | RD_W | Lane 0 destination register |
| lane0_data | output | DATA_W | Lane 0 value |
| lane0_exc | output | 1 | Lane 0 exception flag |
| lane1_vld | output | 1 | Lane 1 carries a result |
| lane1_tag | output | TAG_W | Lane 1 tag |
| lane1_rd | output | RD_W | Lane 1 destination register |
| lane1_data | output | DATA_W | Lane 1 value |
| lane1_exc | output | 1 | Lane 1 exception flag |

## Verification
The lane outputs and `fu_ready` are combinational, so they are due in the same cycle as the offer that causes them. A held result is due no earlier than the cycle after its loss, once it ranks among the top two requesters. The bench drives inputs at the falling edge and computes the expected lanes and ready vector from its own model of the slots. It then samples one time unit later, well before the next rising edge, and moves the model forward only at that rising edge. At the end, the per-tag count of grants is compared with the model's count, which shows whether any held result was dropped or sent twice.

// File: rtl/cdb_arb_pkg.sv
package cdb_arb_pkg;
    // Occupancy of a per-unit holding slot
    typedef enum logic {
        SLOT_EMPTY = 1'b0,
        SLOT_HELD  = 1'b1
    } slot_state_e;

    // Seven completion sources; index order is the grant priority
    // (0 multiply, 1 memory, 2 ALU, 3 int divide, 4 FP divide, 5 FP multiply, 6 FP add)
    localparam int UNIT_COUNT = 7;
endpackage

// File: rtl/cdb_hold_slot.sv
module cdb_hold_slot
    import cdb_arb_pkg::*;
#(
    parameter int PAY_W = 38
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             flush,
    input  logic             done,
    input  logic [PAY_W-1:0] pay_in,
    input  logic             grant,
    output logic             req,
    output logic [PAY_W-1:0] pay_out,
    output logic             ready
);
    slot_state_e      state_q, state_d;
    logic [PAY_W-1:0] held_q;
    logic             load;

    // Next-state decision
    always_comb begin
        state_d = state_q;
        load    = 1'b0;
        if (flush) begin
            state_d = SLOT_EMPTY;
        end else begin
            unique case (state_q)
                SLOT_EMPTY: begin
                    if (done && !grant) begin
                        state_d = SLOT_HELD;
                        load    = 1'b1;
                    end
                end
                SLOT_HELD: begin
                    if (grant) begin
                        if (done) begin
                            load = 1'b1;
                        end else begin
                            state_d = SLOT_EMPTY;
                        end
                    end
                end
                default: state_d = SLOT_EMPTY;
            endcase
        end
    end

    // State and payload registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= SLOT_EMPTY;
            held_q  <= '0;
        end else begin
            state_q <= state_d;
            if (load) begin
                held_q <= pay_in;
            end
        end
    end

    // Outputs: a held result stands in for the unit's fresh output
    always_comb begin
        req     = (state_q == SLOT_HELD) || done;
        pay_out = (state_q == SLOT_HELD) ? held_q : pay_in;
        ready   = flush || (state_q == SLOT_EMPTY) || grant;
    end
endmodule

// File: rtl/cdb_pick2.sv
module cdb_pick2 #(
    parameter int N = 7
) (
    input  logic [N-1:0] req,
    output logic [N-1:0] first_oh,
    output logic [N-1:0] second_oh
);
    logic seen_first;
    logic seen_second;

    // Lowest index wins; the next lowest takes the second lane
    always_comb begin
        first_oh    = '0;
        second_oh   = '0;
        seen_first  = 1'b0;
        seen_second = 1'b0;
        for (int i = 0; i < N; i++) begin
            if (req[i]) begin
                if (!seen_first) begin
                    first_oh[i] = 1'b1;
                    seen_first  = 1'b1;
                end else if (!seen_second) begin
                    second_oh[i] = 1'b1;
                    seen_second  = 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/cdb_two_lane_arb.sv
module cdb_two_lane_arb #(
    parameter int NUM_UNITS = cdb_arb_pkg::UNIT_COUNT,
    parameter int TAG_W     = 5,
    parameter int RD_W      = 5,
    parameter int DATA_W    = 32
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic                             flush,
    input  logic [NUM_UNITS-1:0]             fu_done,
    input  logic [NUM_UNITS-1:0][TAG_W-1:0]  fu_tag,
    input  logic [NUM_UNITS-1:0][RD_W-1:0]   fu_rd,
    input  logic [NUM_UNITS-1:0][DATA_W-1:0] fu_data,
    input  logic [NUM_UNITS-1:0]             fu_exc,
    output logic [NUM_UNITS-1:0]             fu_ready,
    output logic                             lane0_vld,
    output logic [TAG_W-1:0]                 lane0_tag,
    output logic [RD_W-1:0]                  lane0_rd,
    output logic [DATA_W-1:0]                lane0_data,
    output logic                             lane0_exc,
    output logic                             lane1_vld,
    output logic [TAG_W-1:0]                 lane1_tag,
    output logic [RD_W-1:0]                  lane1_rd,
    output logic [DATA_W-1:0]                lane1_data,
    output logic                             lane1_exc
);
    localparam int PAY_W = TAG_W + RD_W + DATA_W + 1;

    logic [NUM_UNITS-1:0] unit_req;
    logic [NUM_UNITS-1:0] live_req;
    logic [NUM_UNITS-1:0] pick0;
    logic [NUM_UNITS-1:0] pick1;
    logic [NUM_UNITS-1:0] unit_grant;
    logic [PAY_W-1:0]     unit_pay [NUM_UNITS];
    logic [PAY_W-1:0]     lane0_pay;
    logic [PAY_W-1:0]     lane1_pay;

    generate
        for (genvar g = 0; g < NUM_UNITS; g++) begin : g_slot
            cdb_hold_slot #(
                .PAY_W(PAY_W)
            ) u_slot (
                .clk     (clk),
                .rst_n   (rst_n),
                .flush   (flush),
                .done    (fu_done[g]),
                .pay_in  ({fu_tag[g], fu_rd[g], fu_data[g], fu_exc[g]}),
                .grant   (unit_grant[g]),
                .req     (unit_req[g]),
                .pay_out (unit_pay[g]),
                .ready   (fu_ready[g])
            );
        end
    endgenerate

    // A flush cycle grants nothing
    assign live_req = unit_req & {NUM_UNITS{~flush}};

    cdb_pick2 #(
        .N(NUM_UNITS)
    ) u_pick (
        .req       (live_req),
        .first_oh  (pick0),
        .second_oh (pick1)
    );

    assign unit_grant = pick0 | pick1;

    // One-hot selected payloads merged onto the lanes
    always_comb begin
        lane0_pay = '0;
        lane1_pay = '0;
        for (int i = 0; i < NUM_UNITS; i++) begin
            lane0_pay = lane0_pay | ({PAY_W{pick0[i]}} & unit_pay[i]);
            lane1_pay = lane1_pay | ({PAY_W{pick1[i]}} & unit_pay[i]);
        end
    end

    assign lane0_vld = |pick0;
    assign lane1_vld = |pick1;
    assign {lane0_tag, lane0_rd, lane0_data, lane0_exc} = lane0_pay;
    assign {lane1_tag, lane1_rd, lane1_data, lane1_exc} = lane1_pay;
endmodule

// File: rtl/cdb_two_lane_arb_chk.sv
module cdb_two_lane_arb_chk #(
    parameter int N = 7
) (
    input logic         clk,
    input logic         rst_n,
    input logic         flush,
    input logic [N-1:0] fu_done,
    input logic [N-1:0] fu_ready,
    input logic         lane0_vld,
    input logic         lane1_vld
);
    // R4: lane 1 never runs without lane 0
    p_lane1_needs_lane0_r4: assert property (@(posedge clk) disable iff (!rst_n)
        lane1_vld |-> lane0_vld);

    // R8: quiet bus during a flush
    p_flush_silent_r8: assert property (@(posedge clk) disable iff (!rst_n)
        flush |-> (!lane0_vld && !lane1_vld));

    // R8: nothing survives a flush into the next cycle
    p_flush_empties_r8: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> ((fu_done != '0) || !lane0_vld));

    // R1: any offered completion yields a grant
    p_busy_grants_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (!flush && (fu_done != '0)) |-> lane0_vld);

    // R1: two or more offers fill both lanes
    p_pair_grants_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (!flush && ($countones(fu_done) >= 2)) |-> lane1_vld);

    generate
        for (genvar gi = 0; gi < N; gi++) begin : g_unit
            // R5: a stalled unit still has a result pending next cycle
            p_stall_keeps_request_r5: assert property (@(posedge clk) disable iff (!rst_n)
                (!flush && !fu_ready[gi]) |=> (flush || lane0_vld));
        end
    endgenerate
endmodule

bind cdb_two_lane_arb cdb_two_lane_arb_chk #(
    .N(NUM_UNITS)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .flush     (flush),
    .fu_done   (fu_done),
    .fu_ready  (fu_ready),
    .lane0_vld (lane0_vld),
    .lane1_vld (lane1_vld)
);

// File: tb/cdb_two_lane_arb_bench.sv
module cdb_two_lane_arb_bench;
    localparam int N   = 7;
    localparam int TW  = 10;
    localparam int RW  = 5;
    localparam int DW  = 16;
    localparam int PW  = TW + RW + DW + 1;
    localparam int NT  = 1 << TW;

    logic                 clk = 1'b0;
    logic                 rst_n = 1'b0;
    logic                 flush = 1'b0;
    logic [N-1:0]         fu_done = '0;
    logic [N-1:0][TW-1:0] fu_tag = '0;
    logic [N-1:0][RW-1:0] fu_rd = '0;
    logic [N-1:0][DW-1:0] fu_data = '0;
    logic [N-1:0]         fu_exc = '0;
    logic [N-1:0]         fu_ready;
    logic                 lane0_vld, lane0_exc, lane1_vld, lane1_exc;
    logic [TW-1:0]        lane0_tag, lane1_tag;
    logic [RW-1:0]        lane0_rd, lane1_rd;
    logic [DW-1:0]        lane0_data, lane1_data;

    always #4 clk = ~clk;

    cdb_two_lane_arb #(.NUM_UNITS(N), .TAG_W(TW), .RD_W(RW), .DATA_W(DW)) u_cdb_two_lane_arb (
        .clk(clk), .rst_n(rst_n), .flush(flush), .fu_done(fu_done), .fu_tag(fu_tag),
        .fu_rd(fu_rd), .fu_data(fu_data), .fu_exc(fu_exc), .fu_ready(fu_ready),
        .lane0_vld(lane0_vld), .lane0_tag(lane0_tag), .lane0_rd(lane0_rd),
        .lane0_data(lane0_data), .lane0_exc(lane0_exc),
        .lane1_vld(lane1_vld), .lane1_tag(lane1_tag), .lane1_rd(lane1_rd),
        .lane1_data(lane1_data), .lane1_exc(lane1_exc));

    typedef struct {
        logic          v0;
        logic [PW-1:0] p0;
        logic          v1;
        logic [PW-1:0] p1;
        logic [N-1:0]  rdy;
        string         lbl;
    } exp_t;

    exp_t          expq [$];
    event          chk_ev;
    int            n_checks = 0;
    int            n_fail = 0;
    bit            done_flag = 0;
    // unit-side pending outputs (held by the unit until accepted)
    logic [N-1:0]  pend_v = '0;
    logic [PW-1:0] pend_p [N];
    // model of the holding slots
    logic [N-1:0]  m_held = '0;
    logic [PW-1:0] m_hp [N];
    int            egc [NT];
    int            gcnt [NT];
    int            next_tag = 0;

    task automatic chk(input bit ok, input string r, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s actual=%h expected=%h", r, what, act, exp);
        end
    endtask

    task automatic offer(input int u);
        logic [RW-1:0] rd;
        logic [DW-1:0] dat;
        rd  = RW'($urandom);
        dat = DW'($urandom);
        pend_p[u] = {TW'(next_tag), rd, dat, 1'($urandom)};
        pend_v[u] = 1'b1;
        next_tag++;
    endtask

    // Drive one cycle, push the expected outcome, advance the model at the edge
    task automatic cycle(input string lbl, input bit fl);
        exp_t          e;
        logic [PW-1:0] pres [N];
        int            first, second;
        @(negedge clk);
        flush = fl;
        for (int i = 0; i < N; i++) begin
            fu_done[i] = pend_v[i];
            {fu_tag[i], fu_rd[i], fu_data[i], fu_exc[i]} = pend_p[i];
            pres[i] = m_held[i] ? m_hp[i] : pend_p[i];
        end
        first = -1;
        second = -1;
        if (!fl) begin
            for (int i = 0; i < N; i++) begin
                if (m_held[i] || pend_v[i]) begin
                    if (first < 0) first = i;
                    else if (second < 0) second = i;
                end
            end
        end
        e.lbl = lbl;
        e.v0 = (first >= 0);
        e.p0 = (first >= 0) ? pres[first] : '0;
        e.v1 = (second >= 0);
        e.p1 = (second >= 0) ? pres[second] : '0;
        for (int i = 0; i < N; i++)
            e.rdy[i] = fl || !m_held[i] || (i == first) || (i == second);
        expq.push_back(e);
        #1;
        ->chk_ev;
        @(posedge clk);
        if (first >= 0) egc[int'(pres[first][PW-1 -: TW])]++;
        if (second >= 0) egc[int'(pres[second][PW-1 -: TW])]++;
        for (int i = 0; i < N; i++) begin
            bit g;
            bit acc;
            g   = (i == first) || (i == second);
            acc = pend_v[i] && e.rdy[i];
            if (fl) begin
                m_held[i] = 1'b0;
            end else if (m_held[i]) begin
                if (g) begin
                    if (acc) m_hp[i] = pend_p[i];
                    else m_held[i] = 1'b0;
                end
            end else if (acc && !g) begin
                m_held[i] = 1'b1;
                m_hp[i] = pend_p[i];
            end
            if (acc) pend_v[i] = 1'b0;
        end
    endtask

    // Monitor: compare the design outputs with the queued expectation
    always @(chk_ev) begin
        exp_t e;
        e = expq.pop_front();
        chk(lane0_vld == e.v0, e.lbl, "lane0 valid", 64'(lane0_vld), 64'(e.v0));
        chk(lane1_vld == e.v1, e.lbl, "lane1 valid", 64'(lane1_vld), 64'(e.v1));
        if (e.v0)
            chk({lane0_tag, lane0_rd, lane0_data, lane0_exc} == e.p0, e.lbl, "lane0 payload",
                64'({lane0_tag, lane0_rd, lane0_data, lane0_exc}), 64'(e.p0));
        if (e.v1)
            chk({lane1_tag, lane1_rd, lane1_data, lane1_exc} == e.p1, e.lbl, "lane1 payload",
                64'({lane1_tag, lane1_rd, lane1_data, lane1_exc}), 64'(e.p1));
        chk(fu_ready == e.rdy, e.lbl, "ready vector", 64'(fu_ready), 64'(e.rdy));
        if (lane0_vld) gcnt[int'(lane0_tag)]++;
        if (lane1_vld) gcnt[int'(lane1_tag)]++;
    end

    task automatic finish_run();
        if (!done_flag) begin
            done_flag = 1;
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    endtask

    initial begin
        #(8 * 200000);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog expired actual=0 expected=1");
        finish_run();
    end

    initial begin
        for (int i = 0; i < N; i++) begin
            pend_p[i] = '0;
            m_hp[i] = '0;
        end
        for (int t = 0; t < NT; t++) begin
            egc[t] = 0;
            gcnt[t] = 0;
        end
        repeat (3) @(posedge clk);
        #1;
        chk(fu_ready == '1 && !lane0_vld && !lane1_vld, "R10", "reset outputs",
            64'({fu_ready, lane0_vld, lane1_vld}), 64'({{N{1'b1}}, 2'b00}));
        rst_n = 1'b1;
        cycle("R10", 0);

        // single requester: the ALU
        offer(2);
        cycle("R3 R4 R9", 0);
        cycle("R3", 0);

        // FP add and multiply together: multiply wins lane 0
        offer(6);
        offer(0);
        cycle("R2", 0);

        // all seven at once, then the losers drain in order
        for (int i = 0; i < N; i++) offer(i);
        cycle("R1 R2", 0);
        for (int k = 0; k < 3; k++) cycle("R5", 0);

        // FP add held behind two higher units; its new output must wait
        offer(0); offer(1); offer(6);
        cycle("R5", 0);
        offer(0); offer(1); offer(6);
        cycle("R6", 0);
        cycle("R7", 0);
        cycle("R7", 0);

        // flush with held and offered results
        for (int i = 0; i < N; i++) offer(i);
        cycle("R1", 0);
        offer(3);
        cycle("R8", 1);
        cycle("R8", 0);

        // random traffic
        for (int k = 0; k < 300; k++) begin
            for (int i = 0; i < N; i++)
                if (!pend_v[i] && ($urandom % 100) < 25 && next_tag < NT - N) offer(i);
            cycle("R1", ($urandom % 50) == 0);
        end
        for (int i = 0; i < N; i++) pend_v[i] = 1'b0;
        for (int k = 0; k < 6; k++) cycle("R1", 0);

        // every result broadcast exactly as often as the model says
        for (int t = 0; t < next_tag; t++)
            chk(gcnt[t] == egc[t], "R5", $sformatf("grant count tag %0d", t),
                64'(gcnt[t]), 64'(egc[t]));
        finish_run();
    end
endmodule